// File: doc/BRIEF.md
# Forward-Difference Cubic Spline Interpolator

This block produces the sample stream of one output channel as a piecewise polynomial of degree zero to three. It uses no multipliers. Four accumulators of growing width hold the value and its three forward differences. On each evolution step, every accumulator adds the aligned upper bits of the accumulator one order above it. The output sample is the order-0 accumulator.

A line parser upstream presents a coefficient record, a line-type tag, a count of valid 16-bit words and a 4-bit rate exponent, and pulses a load strobe. The block accepts the load only when the tag matches its own type parameter. A sequencer drives an increment enable. The block advances one evolution step every 2^E enabled cycles. While the enable is low it holds its value, and it keeps evolving on its current coefficients while lines of other types execute.

Top module: `spline_interp`

## Requirements
- R1: While reset is asserted, every accumulator and the divider are cleared, so `sample_o` reads 0 in the cycle after reset is seen.
- R2: A load with `line_type_i` equal to `LINE_TYPE` captures the record. Word i occupies bits 16i+15..16i. The order-0 offset is word 0, the order-1 increment is words 1..2, the order-2 increment is words 3..5, and the order-3 increment is words 6..8, least significant word first. `sample_o` equals the order-0 offset from the next cycle on.
- R3: Record words at an index greater than or equal to `word_cnt_i` are taken as zero, so a short record gives a lower-order polynomial. A count of 9 or more keeps all words.
- R4: On an evolution step, all accumulators update at once from their old values. Order 0 adds bits 31..16 of order 1. Order 1 adds bits 47..16 of order 2. Order 2 adds all 48 bits of order 3.
- R5: The additions wrap in two's complement at each accumulator's width, with no saturation.
- R6: One evolution step occurs every 2^E cycles in which `inc_en_i` is high. E is the `shift_i` value captured at the accepted load. A load restarts the step count.
- R7: While `inc_en_i` is low and no accepted load occurs, the accumulators and the step count hold.
- R8: A load whose `line_type_i` differs from `LINE_TYPE` has no effect. Evolution continues on the existing coefficients in that cycle and after it.
- R9: When an accepted load and an enabled cycle coincide, the load wins and no step is taken in that cycle.
- R10: The order-3 accumulator changes only on an accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe for the presented line record |
| line_type_i | input | 1 | Output-type tag of the presented line |
| word_cnt_i | input | 4 | Number of valid 16-bit record words |
| coef_i | input | 144 | Concatenated coefficient record, word 0 in the low bits |
| shift_i | input | 4 | Rate exponent E of the presented line |
| inc_en_i | input | 1 | Evolution enable from the sequencer |
| sample_o | output | 16 | Current sample, the order-0 accumulator |

## Verification
The assertions assume that reset is held for at least one clock edge before use, and that `word_cnt_i`, `coef_i` and `shift_i` are stable and meaningful whenever `load_i` is high. They make no assumption about how long `inc_en_i` stays high or low. The stimulus changes inputs only on falling edges and asserts a load only with a full record. It holds each run short enough that the rate check's gap counter cannot wrap. For exponents above 3, only the capture of E is exercised, not a full step period.

// File: rtl/spline_pkg.sv
package spline_pkg;
    localparam int WORD_W    = 16;
    localparam int W0        = 16;
    localparam int W1        = 32;
    localparam int W2        = 48;
    localparam int W3        = 48;
    localparam int COEF_W    = W0 + W1 + W2 + W3;
    localparam int NUM_WORDS = COEF_W / WORD_W;
    localparam int WCNT_W    = 4;
    localparam int SHIFT_W   = 4;
    localparam int TYPE_W    = 1;
    localparam int DIV_W     = 1 << SHIFT_W;

    typedef struct packed {
        logic [W3-1:0] c3;
        logic [W2-1:0] c2;
        logic [W1-1:0] c1;
        logic [W0-1:0] c0;
    } coef_t;

    typedef struct packed {
        logic [W3-1:0] v3;
        logic [W2-1:0] v2;
        logic [W1-1:0] v1;
        logic [W0-1:0] v0;
    } acc_t;

    typedef struct packed {
        logic [DIV_W-1:0]   cnt;
        logic [SHIFT_W-1:0] shift;
    } div_t;
endpackage

// File: rtl/spline_coef_unpack.sv
module spline_coef_unpack
    import spline_pkg::*;
(
    input  logic [COEF_W-1:0] raw_i,
    input  logic [WCNT_W-1:0] word_cnt_i,
    output coef_t             coef_o
);
    logic [COEF_W-1:0] masked;

    // Each record word is kept only when its index lies below the count.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign masked[w*WORD_W +: WORD_W] =
            (int'(word_cnt_i) > w) ? raw_i[w*WORD_W +: WORD_W] : '0;
    end

    assign coef_o = masked;
endmodule

// File: rtl/spline_rate_div.sv
module spline_rate_div
    import spline_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic               inc_en_i,
    output logic               step_o,
    output logic [SHIFT_W-1:0] shift_o
);
    div_t             div_d, div_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        div_d  = div_q;
        step_o = 1'b0;
        limit  = (DIV_W'(1) << div_q.shift) - DIV_W'(1);
        if (restart_i) begin
            div_d.cnt   = '0;
            div_d.shift = shift_i;
        end else if (inc_en_i) begin
            if (div_q.cnt == limit) begin
                step_o    = 1'b1;
                div_d.cnt = '0;
            end else begin
                div_d.cnt = div_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign shift_o = div_q.shift;
endmodule

// File: rtl/spline_acc_chain.sv
module spline_acc_chain
    import spline_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  coef_t coef_i,
    input  logic  step_i,
    output acc_t  acc_o
);
    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (load_i) begin
            acc_d.v0 = coef_i.c0;
            acc_d.v1 = coef_i.c1;
            acc_d.v2 = coef_i.c2;
            acc_d.v3 = coef_i.c3;
        end else if (step_i) begin
            // Each order adds the top bits of the order above, taken before the update.
            acc_d.v0 = acc_q.v0 + acc_q.v1[W1-1 -: W0];
            acc_d.v1 = acc_q.v1 + acc_q.v2[W2-1 -: W1];
            acc_d.v2 = acc_q.v2 + acc_q.v3[W3-1 -: W2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/spline_interp.sv
module spline_interp
    import spline_pkg::*;
#(
    parameter int unsigned LINE_TYPE = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [TYPE_W-1:0]   line_type_i,
    input  logic [WCNT_W-1:0]   word_cnt_i,
    input  logic [COEF_W-1:0]   coef_i,
    input  logic [SHIFT_W-1:0]  shift_i,
    input  logic                inc_en_i,
    output logic [W0-1:0]       sample_o
);
    logic               load_hit;
    logic               step_w;
    logic [SHIFT_W-1:0] shift_q;
    coef_t              coef_w;
    acc_t               acc_q;
    logic [W0-1:0]      slope_hi;
    logic [W3-1:0]      top_q;

    assign load_hit = load_i && (line_type_i == TYPE_W'(LINE_TYPE));

    spline_coef_unpack u_unpack (
        .raw_i      (coef_i),
        .word_cnt_i (word_cnt_i),
        .coef_o     (coef_w)
    );

    spline_rate_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (load_hit),
        .shift_i   (shift_i),
        .inc_en_i  (inc_en_i),
        .step_o    (step_w),
        .shift_o   (shift_q)
    );

    spline_acc_chain u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_hit),
        .coef_i (coef_w),
        .step_i (step_w),
        .acc_o  (acc_q)
    );

    assign slope_hi = acc_q.v1[W1-1 -: W0];
    assign top_q    = acc_q.v3;
    assign sample_o = acc_q.v0;
endmodule

// File: rtl/spline_interp_chk.sv
module spline_interp_chk
    import spline_pkg::*;
#(
    parameter int unsigned LINE_TYPE = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_i,
    input logic [TYPE_W-1:0]  line_type_i,
    input logic [WCNT_W-1:0]  word_cnt_i,
    input logic [WORD_W-1:0]  coef_lo,
    input logic               inc_en_i,
    input logic [W0-1:0]      sample_o,
    input logic               step_w,
    input logic [SHIFT_W-1:0] shift_q,
    input logic [W0-1:0]      slope_hi,
    input logic [W3-1:0]      top_q
);
    logic          hit;
    logic [W0-1:0] exp_a0;
    logic [DIV_W:0] gap_q;

    assign hit    = load_i && (line_type_i == TYPE_W'(LINE_TYPE));
    assign exp_a0 = (word_cnt_i != '0) ? coef_lo : '0;

    // Enabled cycles seen since the last step or accepted load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        gap_q <= '0;
        else if (hit)      gap_q <= '0;
        else if (step_w)   gap_q <= '0;
        else if (inc_en_i) gap_q <= gap_q + 1'b1;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> sample_o == '0);

    a_r2_load_offset: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> sample_o == $past(exp_a0));

    a_r3_short_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && word_cnt_i < 4'd7) |=> top_q == '0);

    a_r4_step_sum: assert property (@(posedge clk) disable iff (!rst_n)
        step_w |=> sample_o == $past(sample_o) + $past(slope_hi));

    a_r6_step_period: assert property (@(posedge clk) disable iff (!rst_n)
        step_w |-> (gap_q + 1'b1) == ((DIV_W+1)'(1) << shift_q));

    a_r7_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !inc_en_i) |=> $stable(sample_o) && $stable(slope_hi));

    a_r7_no_step_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_en_i |-> !step_w);

    a_r9_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !step_w);

    a_r10_top_const: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(top_q));
endmodule

bind spline_interp spline_interp_chk #(.LINE_TYPE(LINE_TYPE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .line_type_i (line_type_i),
    .word_cnt_i  (word_cnt_i),
    .coef_lo     (coef_i[15:0]),
    .inc_en_i    (inc_en_i),
    .sample_o    (sample_o),
    .step_w      (step_w),
    .shift_q     (shift_q),
    .slope_hi    (slope_hi),
    .top_q       (top_q)
);

// File: tb/spline_interp_bench.sv
module spline_interp_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] a0;
        logic [31:0] a1;
        logic [47:0] a2;
        logic [47:0] a3;
        logic [3:0]  words;
        logic [3:0]  shift;
        logic [7:0]  cycles;
        logic [15:0] expect_v;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{16'h0100, 32'h0002_0000, 48'h0, 48'h0, 4'd9, 4'd0, 8'd5, 16'h010A},              // R4 linear
        '{16'h0010, 32'h0, 48'h0001_0000_0000, 48'h0, 4'd9, 4'd0, 8'd4, 16'h0016},          // R4 quadratic
        '{16'h0000, 32'h0, 48'h0, 48'h0001_0000_0000, 4'd9, 4'd0, 8'd6, 16'h0014},          // R4 R10 cubic
        '{16'hFFFE, 32'h0001_0000, 48'h0, 48'h0, 4'd9, 4'd0, 8'd3, 16'h0001},               // R5 wrap up
        '{16'h0005, 32'hFFFF_0000, 48'h0, 48'h0, 4'd9, 4'd0, 8'd7, 16'hFFFE},               // R5 wrap down
        '{16'h0000, 32'h0001_0000, 48'h0, 48'h0, 4'd9, 4'd2, 8'd12, 16'h0003},              // R6 E=2
        '{16'h0100, 32'h0004_0000, 48'h0, 48'h0, 4'd9, 4'd3, 8'd20, 16'h0108},              // R6 E=3
        '{16'h1234, 32'h0005_0000, 48'h0001_0000_0000, 48'h0001_0000_0000, 4'd1, 4'd0, 8'd6, 16'h1234}, // R3 one word
        '{16'h0020, 32'h0003_0000, 48'h0001_0000_0000, 48'h0, 4'd3, 4'd0, 8'd4, 16'h002C},  // R3 three words
        '{16'h0040, 32'h0003_FFFF, 48'h0, 48'h0, 4'd2, 4'd0, 8'd5, 16'h0040},               // R3 two words
        '{16'h0100, 32'h0001_0000, 48'h0, 48'h0, 4'd15, 4'd0, 8'd3, 16'h0103},              // R3 count above 9
        '{16'h0000, 32'h0, 48'h0000_8000_0000, 48'h0, 4'd9, 4'd0, 8'd5, 16'h0004}           // R4 alignment
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [0:0]   line_type_i = '0;
    logic [3:0]   word_cnt_i = '0;
    logic [143:0] coef_i = '0;
    logic [3:0]   shift_i = '0;
    logic         inc_en_i = 1'b0;
    logic [15:0]  sample_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spline_interp u_spline_interp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .line_type_i (line_type_i),
        .word_cnt_i  (word_cnt_i),
        .coef_i      (coef_i),
        .shift_i     (shift_i),
        .inc_en_i    (inc_en_i),
        .sample_o    (sample_o)
    );

    task automatic check(input string tag, input logic [15:0] exp_v);
        checks++;
        if (sample_o !== exp_v) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, sample_o, exp_v);
        end
    endtask

    task automatic present(input logic [15:0] a0, input logic [31:0] a1,
                           input logic [47:0] a2, input logic [47:0] a3,
                           input logic [3:0] words, input logic [3:0] sh,
                           input logic typ, input logic en);
        load_i      = 1'b1;
        line_type_i = typ;
        coef_i      = {a3, a2, a1, a0};
        word_cnt_i  = words;
        shift_i     = sh;
        inc_en_i    = en;
    endtask

    task automatic idle(input logic en);
        load_i   = 1'b0;
        inc_en_i = en;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        ticks(3);
        check("R1 reset state", 16'h0000);
        rst_n = 1'b1;

        // Table walk: load, then run the enabled cycles, then sample.
        for (int i = 0; i < NVEC; i++) begin
            present(VECS[i].a0, VECS[i].a1, VECS[i].a2, VECS[i].a3,
                    VECS[i].words, VECS[i].shift, 1'b0, 1'b0);
            ticks(1);
            idle(1'b1);
            ticks(int'(VECS[i].cycles));
            idle(1'b0);
            check($sformatf("R4/R3/R5/R6 vector %0d", i), VECS[i].expect_v);
        end

        // R2: offset visible the cycle after load, no enable.
        present(16'hBEEF, 32'h0001_0000, 48'h0, 48'h0, 4'd9, 4'd0, 1'b0, 1'b0);
        ticks(1);
        idle(1'b0);
        check("R2 offset after load", 16'hBEEF);
        // R3: zero words gives a zero offset.
        present(16'hBEEF, 32'h0, 48'h0, 48'h0, 4'd0, 4'd0, 1'b0, 1'b0);
        ticks(1);
        idle(1'b0);
        check("R3 zero-count load", 16'h0000);

        // R7: pause holds value.
        present(16'h0100, 32'h0001_0000, 48'h0, 48'h0, 4'd9, 4'd0, 1'b0, 1'b0);
        ticks(1);
        idle(1'b1); ticks(3);
        idle(1'b0); ticks(6);
        check("R7 held during pause", 16'h0103);
        idle(1'b1); ticks(2);
        idle(1'b0);
        check("R7 resume after pause", 16'h0105);

        // R7/R6: divider count holds across a pause.
        present(16'h0200, 32'h0001_0000, 48'h0, 48'h0, 4'd9, 4'd2, 1'b0, 1'b0);
        ticks(1);
        idle(1'b1); ticks(2);
        idle(1'b0); ticks(5);
        idle(1'b1); ticks(1);
        idle(1'b0);
        check("R7 divider held, no step yet", 16'h0200);
        idle(1'b1); ticks(1);
        idle(1'b0);
        check("R7 step on fourth enabled cycle", 16'h0201);

        // R6: shift captured at load; later shift_i ignored.
        present(16'h0300, 32'h0001_0000, 48'h0, 48'h0, 4'd9, 4'd2, 1'b0, 1'b0);
        ticks(1);
        idle(1'b1); shift_i = 4'd0; ticks(4);
        idle(1'b0);
        check("R6 shift latched at load", 16'h0301);

        // R6: a load restarts the step count.
        present(16'h0400, 32'h0001_0000, 48'h0, 48'h0, 4'd9, 4'd1, 1'b0, 1'b0);
        ticks(1);
        idle(1'b1); ticks(1);
        present(16'h0400, 32'h0001_0000, 48'h0, 48'h0, 4'd9, 4'd1, 1'b0, 1'b0);
        ticks(1);
        idle(1'b1); ticks(1);
        idle(1'b0);
        check("R6 load restarts count", 16'h0400);
        idle(1'b1); ticks(1);
        idle(1'b0);
        check("R6 step after restart", 16'h0401);

        // R8: other-type load ignored, evolution continues.
        present(16'h0100, 32'h0001_0000, 48'h0, 48'h0, 4'd9, 4'd0, 1'b0, 1'b0);
        ticks(1);
        idle(1'b1); ticks(2);
        present(16'h7777, 32'h0009_0000, 48'h0, 48'h0, 4'd9, 4'd3, 1'b1, 1'b1);
        ticks(1);
        idle(1'b0);
        check("R8 other-type load ignored", 16'h0103);
        idle(1'b1); ticks(2);
        idle(1'b0);
        check("R8 evolution continues", 16'h0105);

        // R9: load and enable together; load wins.
        idle(1'b1); ticks(1);
        present(16'h0500, 32'h0002_0000, 48'h0, 48'h0, 4'd9, 4'd0, 1'b0, 1'b1);
        ticks(1);
        idle(1'b0);
        check("R9 load wins over step", 16'h0500);
        idle(1'b1); ticks(1);
        idle(1'b0);
        check("R9 step after load", 16'h0502);

        // R10: cubic keeps constant third difference over a long run.
        present(16'h0000, 32'h0, 48'h0, 48'h0001_0000_0000, 4'd9, 4'd0, 1'b0, 1'b0);
        ticks(1);
        idle(1'b1); ticks(10);
        idle(1'b0);
        check("R10 cubic over 10 steps", 16'd120);

        // R1: reset mid-run clears output.
        idle(1'b1); ticks(2);
        rst_n = 1'b0;
        ticks(1);
        check("R1 reset mid-run", 16'h0000);
        rst_n = 1'b1;
        idle(1'b0);
        ticks(1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog R1-flow: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule